// File: doc/BRIEF.md
# Auto-Increment Indirect Memory Port

This block lets a host reach a block of 16-bit static memory through just two registers in its I/O space. One is a pointer register and the other is a data window. The host first loads a start address into the pointer register. Every access to the data window then moves one word at the pointer, and the hardware advances the pointer by one. Reads and writes both advance it, so a buffer can be streamed in or out without rewriting the address.

Bus decoding happens outside this block. It receives one strobe per register operation, per-byte write enables and write data. It returns read data combinationally in the same cycle as the read strobe.

The pointer is 16 bits wide, which spans 64K words. The array behind it is a synchronous RAM whose index width is a parameter. Its default is small, and the pointer's low bits select the word. Setting the index width to 16 gives the full 64K-word array.

A prefetch register always holds the word at the current pointer. A data read therefore needs no wait state.

Top module: `ai_mem_port`

## Requirements
- R1: After reset the pointer is 0x0000. A pointer read returns 0x0000.
- R2: A pointer-register write loads the pointer from `wdata`. A pointer-register read returns the current pointer on `rdata` and leaves the pointer unchanged.
- R3: A data write stores `wdata` into the word at the pointer. The pointer then becomes pointer+1.
- R4: A data read returns the word at the pointer on `rdata` in the same cycle as the strobe. The pointer then becomes pointer+1.
- R5: The pointer wraps from 0xFFFF to 0x0000. The RAM word used is the pointer's low `RAM_AW` bits (default 10, so 0xFFFF selects word 1023).
- R6: `byte_en[0]` enables `wdata[7:0]` and `byte_en[1]` enables `wdata[15:8]`. Lanes that are not enabled keep their old value. A data write advances the pointer even when `byte_en` is 2'b00.
- R7: Data reads on consecutive cycles each return the next word with no idle cycles. This includes words written just before.
- R8: When the pointer write and a data strobe are asserted together, the pointer write wins. No memory word is written and no extra increment happens.
- R9: In a cycle with no pointer write and no data strobe, the pointer keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_wr | input | 1 | Pointer-register write strobe |
| ptr_rd | input | 1 | Pointer-register read strobe (selects pointer onto `rdata`) |
| data_wr | input | 1 | Data-window write strobe |
| data_rd | input | 1 | Data-window read strobe |
| wdata | input | 16 | Write data for either register |
| byte_en | input | 2 | Byte-lane enables for data writes |
| rdata | output | 16 | Pointer value during `ptr_rd`, otherwise the prefetched word |

## Verification
The hardest case to reach is the wrap at the end of the pointer range. It needs a long run of accesses unless the start address sits right at 0xFFFF.

The stimulus loads 0xFFFF directly. It writes across the boundary, reloads 0xFFFF and streams the words back on consecutive cycles. This exercises the wrap, the low-bit aliasing and the prefetch in one pass.

Byte-lane merges and the priority of the pointer write are checked by reading back the exact word the suppressed or partial write could have touched.

// File: rtl/ai_mem_port.sv
module ai_mem_port #(
  parameter int W      = 16,
  parameter int RAM_AW = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ptr_wr,
  input  logic         ptr_rd,
  input  logic         data_wr,
  input  logic         data_rd,
  input  logic [W-1:0] wdata,
  input  logic [W/8-1:0] byte_en,
  output logic [W-1:0] rdata
);
  localparam int DEPTH = 1 << RAM_AW;
  localparam int LANES = W / 8;

  logic [W-1:0] mem [0:DEPTH-1];
  logic [W-1:0] ptr_q, ptr_d, pf_q;
  logic         step, wr_en;

  assign step  = (data_wr | data_rd) & ~ptr_wr;
  assign wr_en = data_wr & ~ptr_wr;

  always_comb begin
    ptr_d = ptr_q;
    if (ptr_wr)    ptr_d = wdata;
    else if (step) ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int l = 0; l < LANES; l++)
        if (byte_en[l]) mem[ptr_q[RAM_AW-1:0]][l*8 +: 8] <= wdata[l*8 +: 8];
    end
    pf_q <= mem[ptr_d[RAM_AW-1:0]];
  end

  assign rdata = ptr_rd ? ptr_q : pf_q;

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr |=> ptr_q == $past(wdata));
  p_step_r3_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_wr && (data_wr || data_rd)) |=> ptr_q == $past(ptr_q) + 1'b1);
  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_wr && (data_wr || data_rd) && ptr_q == {W{1'b1}}) |=> ptr_q == '0);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_wr && !data_wr && !data_rd) |=> $stable(ptr_q));
endmodule

// File: tb/ai_mem_port_tb.sv
module ai_mem_port_tb;
  logic        clk = 0, rst_n = 0;
  logic        ptr_wr = 0, ptr_rd = 0, data_wr = 0, data_rd = 0;
  logic [15:0] wdata = '0;
  logic [1:0]  byte_en = '0;
  logic [15:0] rdata;

  ai_mem_port u_dut (.clk(clk), .rst_n(rst_n), .ptr_wr(ptr_wr), .ptr_rd(ptr_rd),
    .data_wr(data_wr), .data_rd(data_rd), .wdata(wdata), .byte_en(byte_en), .rdata(rdata));

  always #2.5 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] ref_mem [0:1023];
  logic [15:0] ref_ptr = '0;

  always @(negedge clk) begin
    if (rst_n && (data_rd || ptr_rd)) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL unexpected read: actual %h expected none", rdata);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          failures++;
          $display("FAIL %s: actual %h expected %h", t, rdata, e);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000 && !done) begin
      failures++;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic step_in(logic pw, logic pr, logic dw, logic dr, logic [15:0] d, logic [1:0] b);
    @(posedge clk); #1;
    ptr_wr = pw; ptr_rd = pr; data_wr = dw; data_rd = dr; wdata = d; byte_en = b;
  endtask

  task automatic idle();
    step_in(0, 0, 0, 0, 16'h0, 2'b00);
  endtask

  task automatic set_ptr(logic [15:0] a);
    step_in(1, 0, 0, 0, a, 2'b00);
    ref_ptr = a;
  endtask

  task automatic rd_ptr(string t);
    step_in(0, 1, 0, 0, 16'h0, 2'b00);
    exp_q.push_back(ref_ptr); tag_q.push_back(t);
  endtask

  task automatic wr(logic [15:0] d, logic [1:0] b);
    step_in(0, 0, 1, 0, d, b);
    if (b[0]) ref_mem[ref_ptr[9:0]][7:0]  = d[7:0];
    if (b[1]) ref_mem[ref_ptr[9:0]][15:8] = d[15:8];
    ref_ptr = ref_ptr + 1'b1;
  endtask

  task automatic rd(string t);
    step_in(0, 0, 0, 1, 16'h0, 2'b00);
    exp_q.push_back(ref_mem[ref_ptr[9:0]]); tag_q.push_back(t);
    ref_ptr = ref_ptr + 1'b1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    rd_ptr("R1 reset pointer");
    set_ptr(16'h0123); idle();
    rd_ptr("R2 pointer load"); rd_ptr("R2 pointer read holds");
    set_ptr(16'h0010);
    wr(16'hA001, 2'b11); wr(16'hB002, 2'b11); wr(16'hC003, 2'b11);
    rd_ptr("R3 write advances pointer");
    set_ptr(16'h0010);
    rd("R4 read word0"); rd("R7 back-to-back word1"); rd("R7 back-to-back word2");
    rd_ptr("R4 read advances pointer");
    set_ptr(16'hFFFF);
    wr(16'h5A5A, 2'b11); wr(16'hA5A5, 2'b11);
    rd_ptr("R5 wrap to 0x0001");
    set_ptr(16'hFFFF);
    rd("R5 word at 0xFFFF"); rd("R5 word after wrap");
    set_ptr(16'h0200);
    wr(16'h1234, 2'b11); wr(16'h5678, 2'b11);
    set_ptr(16'h0200);
    wr(16'h00AB, 2'b01); wr(16'hCD00, 2'b10); wr(16'hFFFF, 2'b00);
    rd_ptr("R6 byte_en 00 still advances");
    set_ptr(16'h0200);
    rd("R6 low lane merge"); rd("R6 high lane merge"); rd("R6 no-lane write kept");
    set_ptr(16'h0300); wr(16'h7777, 2'b11);
    set_ptr(16'h0300);
    step_in(1, 0, 1, 0, 16'h0300, 2'b11);
    rd_ptr("R8 pointer write wins, no increment");
    rd("R8 suppressed write left word");
    set_ptr(16'h0040); idle(); idle(); idle();
    rd_ptr("R9 idle holds pointer");
    set_ptr(16'h0041); wr(16'h9999, 2'b11);
    set_ptr(16'h0041);
    rd("R7 read of just-written word");
    idle(); idle(); idle();
    done = 1;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R4 pending reads: actual %0d expected 0", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule